// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a memory port that moves whole lines. Every processor address is cut into three parts: the byte position inside a 64-byte line, a set number and a tag. Both ways of the addressed set are looked up in the same cycle. A hit answers on the next cycle without touching memory. A miss stalls the processor while one way of the set is replaced. If that way holds modified data, its contents are first written out to memory as a full line, and the new line is then fetched.

Stores update only the selected byte lanes of one 32-bit word and mark the line modified. Memory sees such a line only when it is evicted. Each way has one recency bit. Read hits and read refills set the bit of that way and clear the bit of the other way, so the way chosen for replacement is the one whose bit is clear. Writes never change the recency bits. Requests that would cross a line boundary are split by the requester before they reach the block.

Top module: `wc_cache2w`

## Requirements
- R1: The address fields are: bits [5:0] give the byte within the line, bits [11:6] give the set (64 sets), and bits [31:12] give the tag. Every memory request carries the line base address, which has bits [5:0] equal to zero.
- R2: A request hits when the indexed set holds a valid way with an equal tag. A hit raises cpu_done in the cycle after acceptance, never raises cpu_stall and issues no memory request.
- R3: A read returns the newest value written to the addressed word. Bits [5:2] select the word in the line, and bits [1:0] have no effect.
- R4: On a write, cpu_be bit i replaces bits 8i+7..8i of the addressed word. Bytes whose enable bit is clear keep their previous value.
- R5: After reset, cpu_stall, cpu_done and mem_req are low and every line is invalid, so the first access to any line misses.
- R6: A refill places the line in way 0 if way 0 is invalid. Otherwise it uses way 1 if way 1 is invalid. Only when both ways are valid is a valid way evicted.
- R7: A read hit or a read refill sets the recency bit of its way and clears the bit of the other way. Writes leave both bits unchanged. When both ways are valid, the victim is the way whose bit is clear, or way 0 if both bits are clear.
- R8: A write hit only marks the line dirty and does not touch memory. A dirty victim is written to memory in full (mem_we=1) at its own line base before the refill read is issued. A clean victim produces no memory write.
- R9: A miss raises cpu_stall from the cycle after acceptance until the response. The response is a one-cycle cpu_done pulse while cpu_stall is low. With a memory that acknowledges L cycles after it sees a request, a clean miss answers L+2 cycles after acceptance and a dirty miss answers 2L+3 cycles after acceptance.
- R10: A write miss first refills the line from memory, then merges the written bytes into it and marks it dirty.
- R11: Once mem_req is raised, it stays high with a stable mem_addr and mem_we until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, accepted on a rising edge while cpu_stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables, bit i covers bits 8i+7..8i |
| cpu_stall | output | 1 | High while a miss is being serviced |
| cpu_done | output | 1 | One-cycle response pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_done for loads |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = write back a line, 0 = read a line |
| mem_addr | output | 32 | Line base address |
| mem_wdata | output | 512 | Line being written back |
| mem_ack | input | 1 | One-cycle completion of the current transfer |
| mem_rdata | input | 512 | Line returned, valid with mem_ack on a read |

## Verification
A hit answers one cycle after acceptance. A clean miss answers L+2 cycles after acceptance and a dirty miss 2L+3 cycles after, where the bench memory uses a latency L of 3. Each access therefore has an exact expected response cycle. Inputs are driven on falling edges, and the bench counts falling edges from acceptance until cpu_done appears. It compares that count against the figure predicted by its own model of tags, valid, dirty and recency bits. The load data, the stall level one cycle after acceptance, the write-back address, the line contents and the order of the write-back and the refill are all sampled on falling edges, which keeps every check clear of the register updates.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } wc_state_e;

    localparam int unsigned WC_WAYS = 2;
endpackage

// File: rtl/wc_hit_detect.sv
module wc_hit_detect #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 20,
    parameter int unsigned WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == look_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/wc_meta_store.sv
module wc_meta_store #(
    parameter int unsigned SETS  = 64,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned WAYS  = 2,
    parameter int unsigned WAY_W = 1,
    parameter int unsigned TAG_W = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]            rd_valid,
    output logic [WAYS-1:0]            rd_dirty,
    output logic [WAYS-1:0]            rd_rec,
    input  logic                       wr_en,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic                       wr_dirty,
    input  logic                       rec_en,
    input  logic [WAY_W-1:0]           rec_way
);
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic [WAYS-1:0]            rec_q   [SETS];
    logic [WAYS-1:0]            rec_oh;

    always_comb begin
        rec_oh          = '0;
        rec_oh[rec_way] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                rec_q[s]   <= '0;
            end
        end else begin
            if (wr_en) begin
                valid_q[idx][wr_way] <= 1'b1;
                dirty_q[idx][wr_way] <= wr_dirty;
            end
            if (rec_en) rec_q[idx] <= rec_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[idx][wr_way] <= wr_tag;
    end

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_rec   = rec_q[idx];
endmodule

// File: rtl/wc_line_store.sv
module wc_line_store #(
    parameter int unsigned SETS   = 64,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned WAYS   = 2,
    parameter int unsigned WAY_W  = 1,
    parameter int unsigned LINE_W = 512
) (
    input  logic                        clk,
    input  logic [IDX_W-1:0]            idx,
    output logic [WAYS-1:0][LINE_W-1:0] rd_lines,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [LINE_W-1:0]           wr_line
);
    logic [LINE_W-1:0] data_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en) data_q[idx][wr_way] <= wr_line;
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) rd_lines[w] = data_q[idx][w];
    end
endmodule

// File: rtl/wc_cache2w.sv
module wc_cache2w
    import wc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 6,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    input  logic [WORD_W/8-1:0]     cpu_be,
    output logic                    cpu_stall,
    output logic                    cpu_done,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [(8<<OFF_W)-1:0]   mem_wdata,
    input  logic                    mem_ack,
    input  logic [(8<<OFF_W)-1:0]   mem_rdata
);
    localparam int unsigned LINE_W = 8 << OFF_W;
    localparam int unsigned SETS   = 1 << IDX_W;
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned BE_W   = WORD_W / 8;
    localparam int unsigned BOFF_W = $clog2(BE_W);
    localparam int unsigned WSEL_W = OFF_W - BOFF_W;
    localparam int unsigned WAYS   = WC_WAYS;
    localparam int unsigned WAY_W  = 1;

    typedef struct packed {
        wc_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [WORD_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic [WAY_W-1:0]  vway;
        logic              done;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] ws,
        input logic [WORD_W-1:0] wd,
        input logic [BE_W-1:0]   be
    );
        logic [LINE_W-1:0] res;
        res = line;
        for (int b = 0; b < int'(BE_W); b++) begin
            if (be[b]) res[int'(ws)*int'(WORD_W) + b*8 +: 8] = wd[b*8 +: 8];
        end
        return res;
    endfunction

    // Lookup address: the live request in idle, the held miss otherwise.
    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_ws;
    logic              unused_byte_bits;

    assign lk_addr          = (r_q.state == ST_IDLE) ? cpu_addr : r_q.addr;
    assign lk_idx           = lk_addr[OFF_W +: IDX_W];
    assign lk_tag           = lk_addr[OFF_W+IDX_W +: TAG_W];
    assign lk_ws            = lk_addr[BOFF_W +: WSEL_W];
    assign unused_byte_bits = ^lk_addr[BOFF_W-1:0];

    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid, rd_dirty, rd_rec;
    logic [WAYS-1:0][LINE_W-1:0] rd_lines;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way, vic_way;
    logic                        meta_wr, meta_dirty, rec_en, line_wr;
    logic [WAY_W-1:0]            meta_way, rec_way, line_way;
    logic [LINE_W-1:0]           line_data, hit_line;
    logic                        mreq_c, mwe_c;
    logic [ADDR_W-1:0]           maddr_c;

    wc_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_hit (
        .way_tag(rd_tag), .way_valid(rd_valid), .look_tag(lk_tag),
        .hit(hit), .hit_way(hit_way)
    );

    wc_meta_store #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_meta (
        .clk(clk), .rst_n(rst_n), .idx(lk_idx),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_rec(rd_rec),
        .wr_en(meta_wr), .wr_way(meta_way), .wr_tag(lk_tag), .wr_dirty(meta_dirty),
        .rec_en(rec_en), .rec_way(rec_way)
    );

    wc_line_store #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W), .LINE_W(LINE_W)) u_data (
        .clk(clk), .idx(lk_idx), .rd_lines(rd_lines),
        .wr_en(line_wr), .wr_way(line_way), .wr_line(line_data)
    );

    assign hit_line = rd_lines[hit_way];

    // Victim: invalid way 0, then invalid way 1, then the way with a clear recency bit.
    always_comb begin
        if (!rd_valid[0])                 vic_way = 1'b0;
        else if (!rd_valid[1])            vic_way = 1'b1;
        else if (rd_rec[0] && !rd_rec[1]) vic_way = 1'b1;
        else                              vic_way = 1'b0;
    end

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        meta_wr    = 1'b0;
        meta_dirty = 1'b0;
        meta_way   = r_q.vway;
        rec_en     = 1'b0;
        rec_way    = r_q.vway;
        line_wr    = 1'b0;
        line_way   = r_q.vway;
        line_data  = mem_rdata;
        mreq_c     = 1'b0;
        mwe_c      = 1'b0;
        maddr_c    = {lk_tag, lk_idx, {OFF_W{1'b0}}};
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        r_d.done  = 1'b1;
                        r_d.rdata = hit_line[lk_ws*WORD_W +: WORD_W];
                        if (cpu_we) begin
                            line_wr    = 1'b1;
                            line_way   = hit_way;
                            line_data  = merge_word(hit_line, lk_ws, cpu_wdata, cpu_be);
                            meta_wr    = 1'b1;
                            meta_way   = hit_way;
                            meta_dirty = 1'b1;
                        end else begin
                            rec_en  = 1'b1;
                            rec_way = hit_way;
                        end
                    end else begin
                        r_d.addr  = cpu_addr;
                        r_d.we    = cpu_we;
                        r_d.wdata = cpu_wdata;
                        r_d.be    = cpu_be;
                        r_d.vway  = vic_way;
                        r_d.state = (rd_valid[vic_way] && rd_dirty[vic_way]) ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mreq_c  = 1'b1;
                mwe_c   = 1'b1;
                maddr_c = {rd_tag[r_q.vway], lk_idx, {OFF_W{1'b0}}};
                if (mem_ack) r_d.state = ST_FILL;
            end
            ST_FILL: begin
                mreq_c = 1'b1;
                if (mem_ack) begin
                    line_wr    = 1'b1;
                    line_data  = r_q.we ? merge_word(mem_rdata, lk_ws, r_q.wdata, r_q.be) : mem_rdata;
                    meta_wr    = 1'b1;
                    meta_dirty = r_q.we;
                    rec_en     = !r_q.we;
                    r_d.rdata  = mem_rdata[lk_ws*WORD_W +: WORD_W];
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_stall = (r_q.state != ST_IDLE);
    assign cpu_done  = r_q.done;
    assign cpu_rdata = r_q.rdata;
    assign mem_req   = mreq_c;
    assign mem_we    = mwe_c;
    assign mem_addr  = maddr_c;
    assign mem_wdata = rd_lines[r_q.vway];
endmodule

// File: rtl/wc_cache2w_chk.sv
module wc_cache2w_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_stall,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_line_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    assert_no_mem_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> !mem_req);

    assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    assert_done_unstalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_stall);

    assert_stall_ends_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> cpu_done);

    assert_fill_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> cpu_done);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind wc_cache2w wc_cache2w_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/tb_wc_cache2w.sv
`timescale 1ns/1ps
module tb_wc_cache2w;
    localparam int MEM_LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic         cpu_stall, cpu_done;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [511:0] mem_rdata = '0;

    always #2 clk = ~clk;

    wc_cache2w dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Golden word contents and backing memory, keyed by word address.
    logic [31:0] gold [logic [29:0]];
    logic [31:0] bk   [logic [29:0]];

    function automatic logic [31:0] init_word(input logic [29:0] wa);
        return ({wa, 2'b00} * 32'h9E3779B1) ^ 32'h0BADF00D;
    endfunction
    function automatic logic [31:0] gold_rd(input logic [29:0] wa);
        if (gold.exists(wa)) return gold[wa];
        return init_word(wa);
    endfunction
    function automatic logic [31:0] bk_rd(input logic [29:0] wa);
        if (bk.exists(wa)) return bk[wa];
        return init_word(wa);
    endfunction

    // Reference model of tags, valid, dirty and recency bits.
    logic [19:0] m_tag [64][2];
    bit          m_val [64][2];
    bit          m_dir [64][2];
    bit          m_rec [64][2];

    int          wb_cnt = 0, fill_cnt = 0, seq = 0, wb_seq = 0, fill_seq = 0;
    logic [31:0] wb_addr_seen = '0, fill_addr_seen = '0;

    // Line memory: acknowledges MEM_LAT falling edges after it sees a request.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && rst_n) begin
                automatic logic        op_we   = mem_we;
                automatic logic [31:0] op_addr = mem_addr;
                automatic logic [511:0] op_data = mem_wdata;
                repeat (MEM_LAT) @(negedge clk);
                if (op_we) begin
                    automatic bit ok = 1'b1;
                    for (int w = 0; w < 16; w++) begin
                        automatic logic [29:0] wa = {op_addr[31:6], 4'(w)};
                        if (op_data[w*32 +: 32] != gold_rd(wa)) ok = 1'b0;
                        bk[wa] = op_data[w*32 +: 32];
                    end
                    check(ok, "R8", "write-back line contents", op_addr, op_addr);
                    wb_cnt++; wb_addr_seen = op_addr; wb_seq = seq++;
                end else begin
                    for (int w = 0; w < 16; w++)
                        mem_rdata[w*32 +: 32] = bk_rd({op_addr[31:6], 4'(w)});
                    fill_cnt++; fill_addr_seen = op_addr; fill_seq = seq++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic do_access(input bit we, input logic [31:0] addr,
                             input logic [31:0] wdata, input logic [3:0] be,
                             input string rq);
        int idx, hw, vic, lat, w0, f0, exp_lat;
        bit exp_wb;
        logic [31:0] exp_wb_addr, exp_rd, merged;
        logic [29:0] wa;
        idx = int'(addr[11:6]);
        wa  = addr[31:2];
        hw  = -1;
        for (int w = 0; w < 2; w++)
            if (m_val[idx][w] && m_tag[idx][w] == addr[31:12]) hw = w;
        vic = 0; exp_wb = 1'b0; exp_wb_addr = '0;
        if (hw < 0) begin
            if (!m_val[idx][0])      vic = 0;
            else if (!m_val[idx][1]) vic = 1;
            else                     vic = (m_rec[idx][0] && !m_rec[idx][1]) ? 1 : 0;
            exp_wb      = m_val[idx][vic] && m_dir[idx][vic];
            exp_wb_addr = {m_tag[idx][vic], addr[11:6], 6'b0};
        end
        exp_lat = (hw >= 0) ? 1 : (exp_wb ? 2*MEM_LAT + 3 : MEM_LAT + 2);
        exp_rd  = gold_rd(wa);
        w0 = wb_cnt; f0 = fill_cnt;

        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata; cpu_be = be;
        @(negedge clk);
        cpu_req = 1'b0;
        if (hw < 0) check(cpu_stall === 1'b1, "R9", "stall after miss acceptance", 64'(cpu_stall), 1);
        lat = 1;
        while (!cpu_done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, rq, "response latency", 64'(lat), 64'(exp_lat));
        check(cpu_stall === 1'b0, "R9", "stall low at response", 64'(cpu_stall), 0);
        if (!we) check(cpu_rdata === exp_rd, "R3", "read data", 64'(cpu_rdata), 64'(exp_rd));
        check(fill_cnt - f0 == ((hw < 0) ? 1 : 0), "R2", "refill count", 64'(fill_cnt - f0), 64'((hw < 0) ? 1 : 0));
        check(wb_cnt - w0 == (exp_wb ? 1 : 0), "R8", "write-back count", 64'(wb_cnt - w0), 64'(exp_wb ? 1 : 0));
        if (hw < 0) check(fill_addr_seen == {addr[31:6], 6'b0}, "R1", "refill line base", 64'(fill_addr_seen), 64'({addr[31:6], 6'b0}));
        if (exp_wb) begin
            check(wb_addr_seen == exp_wb_addr, "R7", "victim line address", 64'(wb_addr_seen), 64'(exp_wb_addr));
            check(wb_seq < fill_seq, "R8", "write-back precedes refill", 64'(wb_seq), 64'(fill_seq));
        end
        @(negedge clk);
        check(cpu_done === 1'b0, "R9", "done is a single pulse", 64'(cpu_done), 0);

        // Advance the model and the golden data.
        if (we) begin
            merged = exp_rd;
            for (int b = 0; b < 4; b++) if (be[b]) merged[b*8 +: 8] = wdata[b*8 +: 8];
            gold[wa] = merged;
        end
        if (hw >= 0) begin
            if (we) m_dir[idx][hw] = 1'b1;
            else begin m_rec[idx][hw] = 1'b1; m_rec[idx][1-hw] = 1'b0; end
        end else begin
            m_tag[idx][vic] = addr[31:12];
            m_val[idx][vic] = 1'b1;
            m_dir[idx][vic] = we;
            if (!we) begin m_rec[idx][vic] = 1'b1; m_rec[idx][1-vic] = 1'b0; end
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int idx, input int off);
        return {20'(tag), 6'(idx), 6'(off)};
    endfunction

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 64; s++)
            for (int w = 0; w < 2; w++) begin
                m_tag[s][w] = '0; m_val[s][w] = 0; m_dir[s][w] = 0; m_rec[s][w] = 0;
            end
        repeat (3) @(negedge clk);
        check(cpu_stall === 1'b0, "R5", "stall in reset", 64'(cpu_stall), 0);
        check(cpu_done === 1'b0, "R5", "done in reset", 64'(cpu_done), 0);
        check(mem_req === 1'b0, "R5", "mem_req in reset", 64'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed sequence in set 5.
        do_access(0, mk(1, 5, 8),  '0, 4'h0, "R5 R6");   // first access misses, way 0
        do_access(0, mk(1, 5, 9),  '0, 4'h0, "R2");      // hit, low bits ignored
        do_access(0, mk(2, 5, 0),  '0, 4'h0, "R6");      // way 1
        do_access(0, mk(1, 5, 4),  '0, 4'h0, "R7");      // way 0 most recent
        do_access(0, mk(3, 5, 0),  '0, 4'h0, "R7");      // evicts way 1
        do_access(0, mk(1, 5, 0),  '0, 4'h0, "R7");      // way 0 survived
        do_access(1, mk(1, 5, 8),  32'hA1B2C3D4, 4'b0101, "R4 R8");
        do_access(0, mk(1, 5, 8),  '0, 4'h0, "R4");
        do_access(1, mk(4, 5, 60), 32'h11223344, 4'b1100, "R10");
        do_access(0, mk(5, 5, 0),  '0, 4'h0, "R8 R10");  // dirty write-allocated line leaves
        do_access(0, mk(4, 5, 60), '0, 4'h0, "R8 R10");  // merged data comes back from memory
        do_access(1, mk(6, 9, 0),  32'hFFFFFFFF, 4'b1111, "R10");

        // Random phase on a small tag and set pool to force conflicts.
        for (int i = 0; i < 700; i++) begin
            automatic bit          we  = $urandom_range(0, 2) == 0;
            automatic logic [31:0] a   = mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 63));
            automatic logic [3:0]  be  = 4'($urandom_range(1, 15));
            do_access(we, a, $urandom, be, "R2 R7 R9");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule